// File: doc/BRIEF.md
# Serial Engine DMA Channel Controller

This block is the register-programmed front end of one DMA direction inside a serial engine. Software writes a 64-bit buffer address as two 32-bit halves and, on the transmit side, an attribute flag. It then writes a byte length. The length write arms the transfer. The block then issues a series of memory requests over a simple request/acknowledge interface. Each request carries a running address and a byte count of up to `BEAT_BYTES`. The block counts the bytes that were acknowledged and stops either at the programmed length or on a bus error response.

Three sticky status events are kept: done, end-of-transfer and bus error. Each one is masked by an enable register that is written only through separate set and clear addresses. A small combiner merges the resulting channel interrupt with the opposite-direction DMA channel and with the primary and secondary sequencer interrupts, under a four-bit top-level enable. The real bus master, address translation and protocol sequencers sit outside the block and reach it only through ports. A mode bit chooses between FIFO operation and DMA operation, and only DMA mode lets a length write start a transfer.

Top module: `sedma_channel`

## Requirements
- R1: After synchronous active-low reset, every register reads zero, and `busy`, `mem_req` and `irq` are low.
- R2: The first request of a transfer presents the address {high half @0x08, low half @0x04} that was latched when the length was written.
- R3: A length write (0x10) arms a transfer only when the mode register (0x00) bit 0 is 1. Otherwise the length is stored for read-back, but no request is issued and the completed-length register does not change.
- R4: Each request asks for min(remaining, BEAT_BYTES) bytes, and the next request's address advances by that amount with a full 64-bit carry. A request keeps its address and size until it is acknowledged or errored.
- R5: When the last byte is acknowledged, status bit 0 (done) is set, `busy` falls, and the completed-length register (0x14) reads the programmed length.
- R6: A zero-length arm sets done in the same cycle, leaves `busy` low, issues no request and writes 0 to the completed length.
- R7: A bus error response ends the transfer. It sets status bit 2, does not set done, and loads the completed length with the bytes acknowledged before the error.
- R8: On the transmit channel, attribute (0x0C) bit 0 requests end-of-transfer marking. If this bit was set when the transfer was armed, completion also sets status bit 1. The attribute register reads back only bit 0.
- R9: Writing ones to 0x24 sets enable bits and writing ones to 0x28 clears enable bits. Bits written as zero keep their value, and 0x20 reads the enables back.
- R10: Writing ones to 0x1C clears the matching status bits (0x18), and all-ones clears every bit. A new event in the same cycle takes priority over the clear.
- R11: `irq` is the OR over the top-level enable (0x2C) applied to the sources: bit 0 receive DMA, bit 1 transmit DMA, bit 2 primary sequencer, bit 3 secondary sequencer. The channel source is the OR of status AND enables. The transmit channel takes bit 1, and `peer_dma_irq` takes the other DMA bit.
- R12: A length write while a transfer is in flight is ignored, and the running transfer completes with its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register; writes with bits [1:0] not zero are dropped |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_addr | output | 64 | Byte address of the current request |
| mem_bytes | output | BYTE_W (3) | Bytes in the current request |
| mem_ack | input | 1 | Request accepted and its bytes moved |
| mem_err | input | 1 | Bus error response to the current request |
| pri_seq_irq | input | 1 | Primary sequencer interrupt |
| sec_seq_irq | input | 1 | Secondary sequencer interrupt |
| peer_dma_irq | input | 1 | Interrupt of the opposite-direction DMA channel |
| busy | output | 1 | Transfer in flight |
| irq | output | 1 | Combined interrupt |

## Verification
The transfer engine is exercised with lengths of 0, 6, 7, 10 and 16 bytes. These separate full beats from a short final beat, and a short final beat from an empty transfer. The acknowledge gap is set to 0, 1 and 2 idle cycles, which shows whether a request holds steady while it waits and does not re-count bytes. One transfer starts two bytes below a 32-bit boundary, so a carry that is lost into the high address half shows up. An error on the second beat shows whether the abort records only the bytes already moved and keeps done clear. Each interrupt source is toggled under different top-level masks, which tells the channel's own bit position apart from the peer channel's bit position.

// File: rtl/sedma_pkg.sv
// Shared constants for the serial engine DMA channel.
// Status bit positions and top-level source positions are decoded by
// software and by neighbouring channels, so they are fixed here.
package sedma_pkg;
    localparam int IRQ_W      = 3;
    localparam int IRQ_DONE   = 0;
    localparam int IRQ_EOT    = 1;
    localparam int IRQ_BUSERR = 2;

    localparam int TOP_W      = 4;
    localparam int TOP_DMA_RX = 0;
    localparam int TOP_DMA_TX = 1;
    localparam int TOP_PRI    = 2;
    localparam int TOP_SEC    = 3;

    localparam int REG_IDX_W  = 4;
    localparam int NUM_REGS   = 12;

    // Register index = byte address / 4
    typedef enum logic [REG_IDX_W-1:0] {
        RG_CTRL     = 4'd0,
        RG_PTR_LO   = 4'd1,
        RG_PTR_HI   = 4'd2,
        RG_ATTR     = 4'd3,
        RG_LEN      = 4'd4,
        RG_LEN_DONE = 4'd5,
        RG_STAT     = 4'd6,
        RG_STAT_CLR = 4'd7,
        RG_EN       = 4'd8,
        RG_EN_SET   = 4'd9,
        RG_EN_CLR   = 4'd10,
        RG_TOP_EN   = 4'd11
    } reg_idx_e;
endpackage

// File: rtl/sedma_regs.sv
// Register file of the DMA channel.
// Holds the mode bit, buffer pointer, attribute, length, interrupt
// enables and top-level enables. Produces the arm strobe and the status
// clear mask. Assumes the write strobe is already qualified for alignment.
module sedma_regs
    import sedma_pkg::*;
#(
    parameter int LEN_W = 20,
    parameter bit IS_TX = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [31:0]          wdata,
    input  logic                 busy,
    input  logic [IRQ_W-1:0]     stat,
    input  logic [LEN_W-1:0]     len_done,
    output logic [63:0]          ptr,
    output logic                 attr_eot,
    output logic [IRQ_W-1:0]     irq_en,
    output logic [TOP_W-1:0]     top_en,
    output logic [IRQ_W-1:0]     stat_clr,
    output logic                 start,
    output logic [LEN_W-1:0]     start_len,
    output logic [31:0]          rdata
);
    logic [NUM_REGS-1:0] wsel;
    logic                dma_mode_q;
    logic [31:0]         ptr_lo_q;
    logic [31:0]         ptr_hi_q;
    logic [LEN_W-1:0]    len_q;
    logic [IRQ_W-1:0]    en_q;
    logic [TOP_W-1:0]    top_q;

    // One-hot write select per register
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            wsel[i] = wr_en && (idx == REG_IDX_W'(i));
        end
    end

    // Mode bit: 1 = DMA mode, 0 = FIFO mode
    always_ff @(posedge clk) begin
        if (!rst_n)               dma_mode_q <= 1'b0;
        else if (wsel[RG_CTRL])   dma_mode_q <= wdata[0];
    end

    // Buffer pointer halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
        end else begin
            if (wsel[RG_PTR_LO]) ptr_lo_q <= wdata;
            if (wsel[RG_PTR_HI]) ptr_hi_q <= wdata;
        end
    end

    // Length register, stored on every write for read-back
    always_ff @(posedge clk) begin
        if (!rst_n)             len_q <= '0;
        else if (wsel[RG_LEN])  len_q <= wdata[LEN_W-1:0];
    end

    // Interrupt enables, written only through set and clear addresses
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= '0;
        else if (wsel[RG_EN_SET])    en_q <= en_q | wdata[IRQ_W-1:0];
        else if (wsel[RG_EN_CLR])    en_q <= en_q & ~wdata[IRQ_W-1:0];
    end

    // Top-level source enables
    always_ff @(posedge clk) begin
        if (!rst_n)                 top_q <= '0;
        else if (wsel[RG_TOP_EN])   top_q <= wdata[TOP_W-1:0];
    end

    // Attribute: end-of-transfer flag exists only on the transmit side
    generate
        if (IS_TX) begin : g_tx_attr
            logic eot_q;
            // End-of-transfer buffer flag
            always_ff @(posedge clk) begin
                if (!rst_n)              eot_q <= 1'b0;
                else if (wsel[RG_ATTR])  eot_q <= wdata[0];
            end
            assign attr_eot = eot_q;
        end else begin : g_rx_attr
            assign attr_eot = 1'b0;
        end
    endgenerate

    assign ptr       = {ptr_hi_q, ptr_lo_q};
    assign irq_en    = en_q;
    assign top_en    = top_q;
    assign start     = wsel[RG_LEN] && dma_mode_q && !busy;
    assign start_len = wdata[LEN_W-1:0];
    assign stat_clr  = wsel[RG_STAT_CLR] ? wdata[IRQ_W-1:0] : '0;

    // Read-back multiplexer
    always_comb begin
        case (idx)
            RG_CTRL:     rdata = {31'b0, dma_mode_q};
            RG_PTR_LO:   rdata = ptr_lo_q;
            RG_PTR_HI:   rdata = ptr_hi_q;
            RG_ATTR:     rdata = {31'b0, attr_eot};
            RG_LEN:      rdata = 32'(len_q);
            RG_LEN_DONE: rdata = 32'(len_done);
            RG_STAT:     rdata = 32'(stat);
            RG_EN:       rdata = 32'(en_q);
            RG_TOP_EN:   rdata = 32'(top_q);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/sedma_xfer.sv
// Transfer engine of the DMA channel.
// Walks the buffer in beats of up to BEAT_BYTES bytes over a
// request/acknowledge interface. A request stays up until it is
// acknowledged or errored. Emits one-cycle done, end-of-transfer and
// error events. Assumes start is asserted only while idle.
module sedma_xfer #(
    parameter  int LEN_W      = 20,
    parameter  int BEAT_BYTES = 4,
    localparam int BYTE_W     = $clog2(BEAT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [63:0]       ptr,
    input  logic              attr_eot,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    output logic [BYTE_W-1:0] mem_bytes,
    output logic              busy,
    output logic              ev_done,
    output logic              ev_eot,
    output logic              ev_err,
    output logic [LEN_W-1:0]  len_done
);
    logic              busy_q;
    logic              eot_q;
    logic [63:0]       addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_done_q;
    logic              tail_beat;
    logic              last_beat;
    logic [BYTE_W-1:0] beat;
    logic              take;

    // Size of the current beat and whether it finishes the buffer
    always_comb begin
        tail_beat = rem_q < LEN_W'(BEAT_BYTES);
        beat      = tail_beat ? BYTE_W'(rem_q) : BYTE_W'(BEAT_BYTES);
        last_beat = tail_beat || (rem_q == LEN_W'(BEAT_BYTES));
    end

    assign take    = busy_q && mem_ack && !mem_err;
    assign ev_err  = busy_q && mem_err;
    assign ev_done = (start && (start_len == '0)) || (take && last_beat);
    assign ev_eot  = ev_done && (busy_q ? eot_q : attr_eot);

    // Transfer state: arm, advance on acknowledge, stop on error or end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            eot_q      <= 1'b0;
            addr_q     <= '0;
            rem_q      <= '0;
            cnt_q      <= '0;
            len_done_q <= '0;
        end else if (start && (start_len != '0)) begin
            busy_q <= 1'b1;
            addr_q <= ptr;
            rem_q  <= start_len;
            cnt_q  <= '0;
            eot_q  <= attr_eot;
        end else if (ev_err) begin
            busy_q     <= 1'b0;
            len_done_q <= cnt_q;
        end else if (take) begin
            addr_q <= addr_q + 64'(beat);
            rem_q  <= rem_q - LEN_W'(beat);
            cnt_q  <= cnt_q + LEN_W'(beat);
            if (last_beat) begin
                busy_q     <= 1'b0;
                len_done_q <= cnt_q + LEN_W'(beat);
            end
        end else if (start) begin
            len_done_q <= '0;
        end
    end

    assign mem_req   = busy_q;
    assign mem_addr  = addr_q;
    assign mem_bytes = beat;
    assign busy      = busy_q;
    assign len_done  = len_done_q;
endmodule

// File: rtl/sedma_irq.sv
// Interrupt status and top-level combiner.
// Keeps the sticky done, end-of-transfer and bus error bits. A new event
// wins over a clear in the same cycle. The masked channel interrupt is
// merged with the peer DMA and the two sequencer sources.
module sedma_irq
    import sedma_pkg::*;
#(
    parameter bit IS_TX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic             ev_eot,
    input  logic             ev_err,
    input  logic [IRQ_W-1:0] stat_clr,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic [TOP_W-1:0] top_en,
    input  logic             pri_irq,
    input  logic             sec_irq,
    input  logic             peer_dma_irq,
    output logic [IRQ_W-1:0] stat,
    output logic             irq
);
    logic [IRQ_W-1:0] set_v;
    logic [IRQ_W-1:0] stat_q;
    logic             chan_irq;
    logic [TOP_W-1:0] src;

    // Gather the event pulses into status positions
    always_comb begin
        set_v             = '0;
        set_v[IRQ_DONE]   = ev_done;
        set_v[IRQ_EOT]    = ev_eot;
        set_v[IRQ_BUSERR] = ev_err;
    end

    // Sticky status with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | set_v;
    end

    assign chan_irq = |(stat_q & irq_en);

    // Place the channel and its peer by direction
    generate
        if (IS_TX) begin : g_tx_src
            assign src[TOP_DMA_TX] = chan_irq;
            assign src[TOP_DMA_RX] = peer_dma_irq;
        end else begin : g_rx_src
            assign src[TOP_DMA_RX] = chan_irq;
            assign src[TOP_DMA_TX] = peer_dma_irq;
        end
    endgenerate

    assign src[TOP_PRI] = pri_irq;
    assign src[TOP_SEC] = sec_irq;
    assign stat         = stat_q;
    assign irq          = |(src & top_en);
endmodule

// File: rtl/sedma_channel.sv
// Top of the serial engine DMA channel for one direction.
// Connects the register file, the transfer engine and the interrupt
// combiner. Register reads are combinational. Writes whose address is not
// word aligned are dropped.
module sedma_channel
    import sedma_pkg::*;
#(
    parameter  int LEN_W      = 20,
    parameter  int BEAT_BYTES = 4,
    parameter  bit IS_TX      = 1'b1,
    localparam int BYTE_W     = $clog2(BEAT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    output logic [BYTE_W-1:0] mem_bytes,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              pri_seq_irq,
    input  logic              sec_seq_irq,
    input  logic              peer_dma_irq,
    output logic              busy,
    output logic              irq
);
    logic                 wr_ok;
    logic [63:0]          ptr;
    logic                 attr_eot;
    logic [IRQ_W-1:0]     irq_en;
    logic [TOP_W-1:0]     top_en;
    logic [IRQ_W-1:0]     stat_clr;
    logic [IRQ_W-1:0]     stat;
    logic                 start;
    logic [LEN_W-1:0]     start_len;
    logic [LEN_W-1:0]     len_done;
    logic                 ev_done;
    logic                 ev_eot;
    logic                 ev_err;

    assign wr_ok = reg_wr_en && (reg_addr[1:0] == 2'b00);

    sedma_regs #(
        .LEN_W (LEN_W),
        .IS_TX (IS_TX)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .idx       (reg_addr[5:2]),
        .wdata     (reg_wdata),
        .busy      (busy),
        .stat      (stat),
        .len_done  (len_done),
        .ptr       (ptr),
        .attr_eot  (attr_eot),
        .irq_en    (irq_en),
        .top_en    (top_en),
        .stat_clr  (stat_clr),
        .start     (start),
        .start_len (start_len),
        .rdata     (reg_rdata)
    );

    sedma_xfer #(
        .LEN_W      (LEN_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_len (start_len),
        .ptr       (ptr),
        .attr_eot  (attr_eot),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_bytes (mem_bytes),
        .busy      (busy),
        .ev_done   (ev_done),
        .ev_eot    (ev_eot),
        .ev_err    (ev_err),
        .len_done  (len_done)
    );

    sedma_irq #(
        .IS_TX (IS_TX)
    ) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_done      (ev_done),
        .ev_eot       (ev_eot),
        .ev_err       (ev_err),
        .stat_clr     (stat_clr),
        .irq_en       (irq_en),
        .top_en       (top_en),
        .pri_irq      (pri_seq_irq),
        .sec_irq      (sec_seq_irq),
        .peer_dma_irq (peer_dma_irq),
        .stat         (stat),
        .irq          (irq)
    );
endmodule

// File: rtl/sedma_channel_chk.sv
// Protocol checker for sedma_channel, attached with bind.
// Watches the memory interface, the status register and the combined
// interrupt. Assumes synchronous active-low reset.
module sedma_channel_chk
    import sedma_pkg::*;
#(
    parameter  int LEN_W      = 20,
    parameter  int BEAT_BYTES = 4,
    localparam int BYTE_W     = $clog2(BEAT_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [5:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic [63:0]       mem_addr,
    input logic [BYTE_W-1:0] mem_bytes,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              busy,
    input logic              irq,
    input logic [TOP_W-1:0]  top_en,
    input logic [IRQ_W-1:0]  stat
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_bytes)));

    p_beat_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_bytes != '0) && (mem_bytes <= BYTE_W'(BEAT_BYTES))));

    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_addr == 6'h10) && (reg_wdata[LEN_W-1:0] == '0) && !busy) |=> !mem_req);

    p_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (!busy && stat[IRQ_BUSERR]));

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (top_en == '0) |-> !irq);
endmodule

bind sedma_channel sedma_channel_chk #(
    .LEN_W      (LEN_W),
    .BEAT_BYTES (BEAT_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_bytes (mem_bytes),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .busy      (busy),
    .irq       (irq),
    .top_en    (top_en),
    .stat      (stat)
);

// File: tb/tb_sedma_channel.sv
// Bench for sedma_channel: a behavioural model updated on every rising
// edge and compared against the ports on every falling edge, plus directed
// register read-back checks.
module tb_sedma_channel;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LEN_W  = 20;
    localparam int BEAT   = 4;
    localparam int BYTE_W = $clog2(BEAT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [5:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req;
    logic [63:0]       mem_addr;
    logic [BYTE_W-1:0] mem_bytes;
    logic              mem_ack = 1'b0;
    logic              mem_err = 1'b0;
    logic              pri = 1'b0;
    logic              sec = 1'b0;
    logic              peer = 1'b0;
    logic              busy;
    logic              irq;

    int checks = 0;
    int failures = 0;

    // responder configuration
    int ack_gap = 0;
    int err_beat = -1;
    int beat_no = 0;
    int wait_cnt = 0;

    // model state
    bit          m_busy = 0, m_mode = 0, m_attr = 0, m_eot = 0;
    logic [63:0] m_ptr = '0, m_addr = '0;
    int          m_rem = 0, m_cnt = 0, m_len_in = 0, by = 0;
    logic [2:0]  m_stat = '0, m_en = '0, set_b = '0, clr_b = '0;
    logic [3:0]  m_top = '0, ridx = '0;
    bit          wr_ok = 0;

    sedma_channel #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT), .IS_TX(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_ack(mem_ack),
        .mem_err(mem_err), .pri_seq_irq(pri), .sec_seq_irq(sec),
        .peer_dma_irq(peer), .busy(busy), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_mode = 0; m_attr = 0; m_eot = 0; m_ptr = '0; m_addr = '0;
            m_rem = 0; m_cnt = 0; m_len_in = 0; m_stat = '0; m_en = '0; m_top = '0;
        end else begin
            set_b = '0; clr_b = '0;
            ridx  = reg_addr[5:2];
            wr_ok = reg_wr_en && (reg_addr[1:0] == 2'b00);
            if (m_busy) begin
                by = (m_rem < BEAT) ? m_rem : BEAT;
                if (mem_err) begin
                    set_b[2] = 1'b1; m_busy = 0; m_len_in = m_cnt;
                end else if (mem_ack) begin
                    m_cnt = m_cnt + by; m_addr = m_addr + 64'(by); m_rem = m_rem - by;
                    if (m_rem == 0) begin
                        m_busy = 0; set_b[0] = 1'b1; set_b[1] = m_eot; m_len_in = m_cnt;
                    end
                end
            end else if (wr_ok && ridx == 4'd4 && m_mode) begin
                if (reg_wdata[LEN_W-1:0] == '0) begin
                    set_b[0] = 1'b1; set_b[1] = m_attr; m_len_in = 0;
                end else begin
                    m_busy = 1; m_addr = m_ptr; m_rem = int'(reg_wdata[LEN_W-1:0]);
                    m_cnt = 0; m_eot = m_attr;
                end
            end
            if (wr_ok) begin
                case (ridx)
                    4'd0:  m_mode = reg_wdata[0];
                    4'd1:  m_ptr[31:0] = reg_wdata;
                    4'd2:  m_ptr[63:32] = reg_wdata;
                    4'd3:  m_attr = reg_wdata[0];
                    4'd7:  clr_b = reg_wdata[2:0];
                    4'd9:  m_en = m_en | reg_wdata[2:0];
                    4'd10: m_en = m_en & ~reg_wdata[2:0];
                    4'd11: m_top = reg_wdata[3:0];
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~clr_b) | set_b;
        end
    end

    // Per-cycle comparison of the ports with the model
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            check("R4/R5 busy", 64'(busy), 64'(m_busy));
            check("R6/R3 mem_req", 64'(mem_req), 64'(m_busy));
            if (m_busy) begin
                check("R2/R4 mem_addr", mem_addr, m_addr);
                check("R4 mem_bytes", 64'(mem_bytes), 64'((m_rem < BEAT) ? m_rem : BEAT));
            end
            check("R11 irq", 64'(irq),
                  64'(|({sec, pri, |(m_stat & m_en), peer} & m_top)));
        end
    end

    // Memory responder
    initial forever begin
        @(negedge clk);
        if (mem_req) begin
            if (wait_cnt >= ack_gap) begin
                if (beat_no == err_beat) begin mem_err = 1'b1; mem_ack = 1'b0; end
                else begin mem_ack = 1'b1; mem_err = 1'b0; end
                beat_no++;
                wait_cnt = 0;
            end else begin
                mem_ack = 1'b0; mem_err = 1'b0; wait_cnt++;
            end
        end else begin
            mem_ack = 1'b0; mem_err = 1'b0;
        end
    end

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 6'(idx * 4); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = 6'(idx * 4);
        #1;
        check(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic setup_resp(input int gap, input int errb);
        ack_gap = gap; err_beat = errb; beat_no = 0; wait_cnt = 0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int i = 0; i < 12; i++) rd(i, 32'h0, "R1 reset register");
        check("R1 busy after reset", 64'(busy), 0);
        check("R1 irq after reset", 64'(irq), 0);

        // R3: FIFO mode ignores the arm
        wr(1, 32'h1000);
        wr(4, 32'd8);
        repeat (3) @(negedge clk);
        check("R3 no transfer in fifo mode", 64'(busy), 0);
        rd(5, 32'h0, "R3 completed length unchanged");
        rd(6, 32'h0, "R3 no status");
        rd(4, 32'd8, "R3 length stored");

        // R2/R5/R12: transfer with slow acknowledge, rewrite of length ignored
        wr(0, 32'h1);
        wr(1, 32'h3456_7000);
        wr(2, 32'h12);
        wr(9, 32'h7);
        wr(11, 32'h2);
        setup_resp(2, -1);
        wr(4, 32'd10);
        #1;
        check("R5 busy after arm", 64'(busy), 1);
        check("R2 first address", mem_addr, 64'h12_3456_7000);
        wr(4, 32'd100);
        wait_idle();
        rd(6, 32'h1, "R5 done status");
        rd(5, 32'd10, "R12 original length completed");
        check("R11 irq from tx channel", 64'(irq), 1);

        // R10: clear done
        wr(7, 32'h1);
        rd(6, 32'h0, "R10 status cleared");
        check("R10 irq dropped", 64'(irq), 0);

        // R9: set/clear enables
        wr(10, 32'h5);
        rd(8, 32'h2, "R9 clear only ones");
        wr(9, 32'h1);
        rd(8, 32'h3, "R9 set only ones");

        // R8: end-of-transfer attribute
        wr(3, 32'hFFFF_FFFF);
        rd(3, 32'h1, "R8 attribute read-back");
        setup_resp(1, -1);
        wr(4, 32'd6);
        wait_idle();
        rd(6, 32'h3, "R8 done plus eot");
        rd(5, 32'd6, "R5 length 6");
        wr(7, 32'hFFFF_FFFF);
        rd(6, 32'h0, "R10 all-ones clear");

        // R6: zero length
        wr(3, 32'h0);
        wr(4, 32'd0);
        #1;
        check("R6 no busy", 64'(busy), 0);
        rd(6, 32'h1, "R6 done at once");
        rd(5, 32'h0, "R6 completed length zero");

        // R7: bus error on second beat
        wr(7, 32'h7);
        setup_resp(0, 1);
        wr(4, 32'd16);
        wait_idle();
        rd(6, 32'h4, "R7 error without done");
        rd(5, 32'd4, "R7 bytes before error");
        check("R7 stopped", 64'(busy), 0);

        // R4: carry across the low half, short last beat
        wr(7, 32'h7);
        wr(1, 32'hFFFF_FFFE);
        wr(2, 32'h0);
        setup_resp(0, -1);
        wr(4, 32'd7);
        #1;
        check("R4 first beat address", mem_addr, 64'hFFFF_FFFE);
        check("R4 first beat size", 64'(mem_bytes), 4);
        @(negedge clk);
        #1;
        check("R4 carried address", mem_addr, 64'h1_0000_0002);
        check("R4 tail size", 64'(mem_bytes), 3);
        wait_idle();
        rd(5, 32'd7, "R4 length 7");

        // R11: combiner
        wr(7, 32'h7);
        wr(11, 32'hF);
        wr(10, 32'h7);
        #1;
        check("R11 all quiet", 64'(irq), 0);
        @(negedge clk); pri = 1'b1; #1;
        check("R11 primary bit2", 64'(irq), 1);
        @(negedge clk); pri = 1'b0; sec = 1'b1; #1;
        check("R11 secondary bit3", 64'(irq), 1);
        wr(11, 32'h3);
        #1;
        check("R11 secondary masked", 64'(irq), 0);
        @(negedge clk); peer = 1'b1; #1;
        check("R11 peer on bit0", 64'(irq), 1);
        wr(11, 32'h2);
        #1;
        check("R11 peer masked by bit0", 64'(irq), 0);
        @(negedge clk); peer = 1'b0; sec = 1'b0;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule